// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked host and an external asynchronous static RAM of 128K words by 8 bits. The host issues one word at a time through a request/ready handshake: a 17-bit address, a direction bit and, for a write, 8 bits of data. The controller latches the request, drives the active-low chip select, output enable and write enable pins in a fixed sequence, and returns read data with a one-cycle valid pulse.

All memory timing minimums are parameters counted in clock cycles. The read window is held for the longer of the cycle time and the access time. A write starts with a one-cycle setup phase in which the data bus is already driven. Write enable is then held low long enough to meet the pulse width, the data setup before its rising edge and the cycle time. After a read, a write is delayed by a parameterised number of quiet cycles so that the memory has released the shared data bus before the controller drives it.

The reset input is asynchronous and active low, and is expected to be released in step with the clock by logic upstream.

Top module: `sram_ctrl`

## Requirements
- R1: During and after reset, with no request: req_ready is 1, rd_valid is 0, mem_cs_n, mem_oe_n and mem_we_n are all 1, and mem_dq_oe is 0.
- R2: An accepted read holds mem_cs_n=0, mem_oe_n=0 and mem_we_n=1 for exactly RD_LEN = max(T_RC, T_AA) consecutive cycles, beginning in the cycle after acceptance, with mem_addr equal to the requested address.
- R3: On the last cycle of the read window the value on mem_dq_in is captured. In the next cycle rd_valid is 1 for one cycle only, rd_data holds the captured byte and req_ready is 1.
- R4: An accepted write produces one setup cycle (mem_cs_n=0, mem_we_n=1, mem_oe_n=1, mem_dq_oe=1). This is followed by WP_LEN = max(T_WP, T_DW-1, T_RC-1, 1) cycles with mem_we_n=0, mem_cs_n=0 and mem_dq_oe=1. mem_dq_out carries the request data through all these cycles, and mem_we_n and mem_dq_oe are released in the same cycle.
- R5: mem_dq_oe is 1 only in the write setup and pulse cycles, and never while mem_oe_n is 0.
- R6: A write accepted while the previous memory operation was a read first spends T_TURN cycles with mem_cs_n=1 and mem_dq_oe=0 before its setup cycle.
- R7: From acceptance until the operation ends, req_ready is 0 and req_valid, req_write, req_addr and req_wdata have no effect.
- R8: mem_addr and mem_dq_out keep the values latched at acceptance for the whole operation, even when the host inputs change.
- R9: A write that follows a write, and any read, begins its strobes in the cycle right after acceptance with no turnaround. Each operation is followed by one idle cycle with req_ready=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| rd_data | output | DATA_W | Captured read data |
| rd_valid | output | 1 | One-cycle pulse, rd_data is new |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | DATA_W | Data driven to the memory |
| mem_dq_oe | output | 1 | 1 = controller drives the data bus |
| mem_dq_in | input | DATA_W | Data returned by the memory |

## Verification
Suppose the sequencer state or its cycle counter goes wrong. A strobe window then becomes one cycle too long or too short, and this is visible at the memory pins in that same operation. The handshake also shifts: req_ready and rd_valid appear a cycle early or late. A lost read flag shows up as a write that drives the bus with no quiet cycles right after a read. A capture taken too early returns a byte that the bench memory has not yet made valid. Each of these is observable within one memory operation.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_RD,
    ST_WSU,
    ST_WP
  } seq_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W   = 2,
  parameter int RD_LD   = 0,
  parameter int WP_LD   = 0,
  parameter int TURN_LD = 0,
  parameter bit TURN_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_done,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             capture,
  output logic             cs_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             dq_oe,
  output logic             idle
);

  seq_state_e st_q, st_d;
  logic       last_rd_q, last_rd_d;

  always_comb begin
    st_d      = st_q;
    last_rd_d = last_rd_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    accept    = 1'b0;
    capture   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept   = 1'b1;
          tmr_load = 1'b1;
          if (!req_write) begin
            st_d    = ST_RD;
            tmr_val = CNT_W'(RD_LD);
          end else if (last_rd_q && TURN_EN) begin
            st_d    = ST_TURN;
            tmr_val = CNT_W'(TURN_LD);
          end else begin
            st_d    = ST_WSU;
          end
        end
      end
      ST_TURN: if (tmr_done) st_d = ST_WSU;
      ST_RD: begin
        last_rd_d = 1'b1;
        if (tmr_done) begin
          capture = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      ST_WSU: begin
        last_rd_d = 1'b0;
        tmr_load  = 1'b1;
        tmr_val   = CNT_W'(WP_LD);
        st_d      = ST_WP;
      end
      ST_WP: if (tmr_done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      last_rd_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      last_rd_q <= last_rd_d;
    end
  end

  assign idle  = (st_q == ST_IDLE);
  assign cs_n  = !((st_q == ST_RD) || (st_q == ST_WSU) || (st_q == ST_WP));
  assign oe_n  = (st_q != ST_RD);
  assign we_n  = (st_q != ST_WP);
  assign dq_oe = (st_q == ST_WSU) || (st_q == ST_WP);

endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              rvalid_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= dq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid_q <= 1'b0;
    else        rvalid_q <= capture;
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int T_RC   = 1,
  parameter int T_AA   = 1,
  parameter int T_WP   = 1,
  parameter int T_DW   = 1,
  parameter int T_TURN = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int RD_LEN  = imax(imax(T_RC, T_AA), 1);
  localparam int WP_LEN  = imax(imax(T_WP, T_DW - 1), imax(T_RC - 1, 1));
  localparam bit TURN_EN = (T_TURN > 0);
  localparam int TURN_LD = TURN_EN ? T_TURN - 1 : 0;
  localparam int MAX_LD  = imax(imax(RD_LEN, WP_LEN), imax(T_TURN, 1));
  localparam int CNT_W   = $clog2(MAX_LD + 1);

  logic             tmr_load, tmr_done, accept, capture, idle;
  logic [CNT_W-1:0] tmr_val;

  sram_ctrl_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sram_ctrl_seq #(
    .CNT_W   (CNT_W),
    .RD_LD   (RD_LEN - 1),
    .WP_LD   (WP_LEN - 1),
    .TURN_LD (TURN_LD),
    .TURN_EN (TURN_EN)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .tmr_done  (tmr_done),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .accept    (accept),
    .capture   (capture),
    .cs_n      (mem_cs_n),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .dq_oe     (mem_dq_oe),
    .idle      (idle)
  );

  sram_ctrl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .dq_in     (mem_dq_in),
    .addr_q    (mem_addr),
    .wdata_q   (mem_dq_out),
    .rdata_q   (rd_data),
    .rvalid_q  (rd_valid)
  );

  assign req_ready = idle;

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);

  assert_read_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_cs_n && mem_we_n && !req_ready));

  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_valid_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> req_ready);

  assert_we_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_dq_oe && !mem_cs_n));

  assert_we_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(mem_dq_oe));

  assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !$past(mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rd_valid   (rd_valid),
  .mem_addr   (mem_addr),
  .mem_dq_out (mem_dq_out),
  .mem_cs_n   (mem_cs_n),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/tb_sram_ctrl.sv
module tb_sram_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 17;
  localparam int DW = 8;
  localparam int T_RC = 4, T_AA = 3, T_WP = 2, T_DW = 3, T_TURN = 2;
  localparam int RD_LEN = (T_RC > T_AA) ? T_RC : T_AA;
  localparam int WP_LEN = 3; // max(T_WP, T_DW-1, T_RC-1, 1)
  localparam int NSWEEP = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rd_valid, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] rd_data, mem_dq_out, mem_dq_in;
  logic [AW-1:0] mem_addr;

  int checks = 0;
  int errors = 0;
  int rcnt = 0;
  logic [DW-1:0] model [0:1023];

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .T_RC(T_RC), .T_AA(T_AA),
              .T_WP(T_WP), .T_DW(T_DW), .T_TURN(T_TURN)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  // memory model: data valid only after T_AA cycles of read strobes
  always @(posedge clk) begin
    if (!mem_cs_n && !mem_oe_n && mem_we_n) rcnt <= rcnt + 1;
    else rcnt <= 0;
    if (!mem_cs_n && !mem_we_n && mem_dq_oe) model[mem_addr[9:0]] <= mem_dq_out;
  end
  assign mem_dq_in = (!mem_cs_n && !mem_oe_n && mem_we_n && rcnt >= T_AA - 1)
                     ? model[mem_addr[9:0]] : 8'hEE;

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return a[7:0] ^ {a[15:9], a[16]} ^ 8'h3C;
  endfunction

  function automatic logic [AW-1:0] sweep_addr(input int i);
    return AW'(i * 2053);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_strobes(input string tag, input logic cs, input logic oe,
                             input logic we, input logic dqoe);
    chk({mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe} == {cs, oe, we, dqoe}, tag,
        {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe}, {cs, oe, we, dqoe});
  endtask

  // Called at a negedge with the controller idle; returns at the negedge of the idle cycle after.
  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
    chk(req_ready == 1'b1, "R9 ready before read", req_ready, 1);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    for (int k = 1; k <= RD_LEN; k++) begin
      // R7: garbage requests while busy are ignored
      req_valid = (k < RD_LEN); req_write = 1'b1; req_addr = ~a; req_wdata = 8'hA5;
      chk_strobes("R2 read strobes", 1'b0, 1'b0, 1'b1, 1'b0);
      chk(mem_addr == a, "R8 read address", mem_addr, a);
      chk(req_ready == 1'b0 && rd_valid == 1'b0, "R7 busy during read", {req_ready, rd_valid}, 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(rd_valid == 1'b1 && req_ready == 1'b1, "R3 valid with ready", {rd_valid, req_ready}, 3);
    chk(rd_data == exp, "R3 read data", rd_data, exp);
    chk_strobes("R2 read window ends", 1'b1, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit after_rd);
    chk(req_ready == 1'b1, "R9 ready before write", req_ready, 1);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = ~a; req_wdata = ~d;
    chk(rd_valid == 1'b0, "R3 valid is one pulse", rd_valid, 0);
    if (after_rd) begin
      for (int k = 0; k < T_TURN; k++) begin
        chk_strobes("R6 turnaround quiet", 1'b1, 1'b1, 1'b1, 1'b0);
        chk(req_ready == 1'b0, "R7 busy in turnaround", req_ready, 0);
        @(negedge clk);
      end
    end
    chk_strobes("R4 setup cycle", 1'b0, 1'b1, 1'b1, 1'b1);
    chk(mem_dq_out == d && mem_addr == a, "R8 setup data/addr", {mem_addr, mem_dq_out}, {a, d});
    @(negedge clk);
    for (int k = 1; k <= WP_LEN; k++) begin
      req_valid = (k < WP_LEN);
      chk_strobes("R4 write pulse", 1'b0, 1'b1, 1'b0, 1'b1);
      chk(mem_dq_out == d && mem_addr == a, "R8 pulse data/addr", {mem_addr, mem_dq_out}, {a, d});
      chk(req_ready == 1'b0, "R7 busy in write", req_ready, 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk_strobes("R4 we and bus released", 1'b1, 1'b1, 1'b1, 1'b0);
    chk(req_ready == 1'b1, "R9 idle after write", req_ready, 1);
  endtask

  // R5: continuous contention monitor
  always @(negedge clk) begin
    if (rst_n && mem_dq_oe && !mem_oe_n)
      chk(1'b0, "R5 bus contention", 1, 0);
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs in reset
    chk_strobes("R1 strobes in reset", 1'b1, 1'b1, 1'b1, 1'b0);
    chk(req_ready == 1'b1 && rd_valid == 1'b0, "R1 handshake in reset", {req_ready, rd_valid}, 2);
    rst_n = 1'b1;
    @(negedge clk);
    chk_strobes("R1 strobes after reset", 1'b1, 1'b1, 1'b1, 1'b0);

    // corners, then a sweep of writes back to back (R9: no turnaround)
    do_write(17'h1FFFF, pat(17'h1FFFF), 1'b0);
    for (int i = 0; i < NSWEEP; i++)
      do_write(sweep_addr(i), pat(sweep_addr(i)), 1'b0);
    // read back after a write: no turnaround (R9)
    do_read(17'h1FFFF, pat(17'h1FFFF));
    for (int i = 0; i < NSWEEP; i++)
      do_read(sweep_addr(i), pat(sweep_addr(i)));
    // read followed by write needs turnaround (R6), then read new value
    for (int i = 0; i < NSWEEP; i++) begin
      do_read(sweep_addr(i), pat(sweep_addr(i)));
      do_write(sweep_addr(i), ~pat(sweep_addr(i)), 1'b1);
      do_read(sweep_addr(i), ~pat(sweep_addr(i)));
    end
    // idle gap after a read still gives turnaround (R6)
    do_read(17'h1FFFF, pat(17'h1FFFF));
    repeat (3) @(negedge clk);
    chk(rd_valid == 1'b0, "R3 no repeat pulse", rd_valid, 0);
    do_write(17'h1FFFF, 8'h00, 1'b1);
    do_read(17'h1FFFF, 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule